// File: doc/BRIEF.md
# Programmable-Duty Square Wave Channel

This block produces a single square-wave voice for a retro sound unit. Software programs it with byte-wide writes to four local offsets: a duty selector, an 11-bit period split over a low and a high byte, and one offset the block does not use. A CPU-rate clock enable drives the block. A divide-by-two stage turns that enable into a slower tick for an 11-bit down-counting period timer. Each time the timer expires, it steps an 8-position duty sequencer downward.

The 4-bit level sent to the mixer is the envelope volume supplied from outside. It is forced to zero in four cases: the current pattern bit is clear, the sweep unit asks for silence, the length counter has run out, or the programmed period is too short to be audible. A write to the high period byte restarts the sequence and sends a one-cycle restart pulse to the envelope generator. The envelope, sweep and length logic are outside this block and reach it as plain inputs.

Top module: `sqch_core`

## Requirements
- R1: After reset the level output is 0 and the envelope restart output is 0. The period, duty and sequencer position are all cleared.
- R2: The period t is made of wr_data[7:0] written at offset 2 (low bits) and wr_data[2:0] written at offset 3 (bits 10:8). With cpu_ce high on every clock, the output waveform repeats every 16*(t+1) clocks.
- R3: The duty field is wr_data[7:6] at offset 0. Over one full waveform period the output is high for this many clocks: 2*(t+1) for duty 0, 4*(t+1) for duty 1, 8*(t+1) for duty 2 and 12*(t+1) for duty 3.
- R4: The sequencer position starts at 0 and moves down by one on each timer expiry, wrapping from 0 to 7. At position p, the pattern bit is bit p of 8'b00000010 for duty 0, 8'b00000110 for duty 1, 8'b00011110 for duty 2 and 8'b11111001 for duty 3.
- R5: Writing a new duty value keeps the current sequencer position, so the output at once follows the new pattern at the same position.
- R6: Any write to offset 3 sets the sequencer position to 0. It also raises env_restart for exactly one clock, in the cycle after the write.
- R7: While the period is below 8 the level is 0. A period of exactly 8 is audible.
- R8: The level is 0 whenever sweep_mute is 1 or len_active is 0. Otherwise, on a set pattern bit with an audible period, the level equals env_vol.
- R9: A write to offset 1 changes neither the duty, the period nor the sequencer position, and it produces no envelope restart.
- R10: The period timer counts only on every second cpu_ce pulse. With cpu_ce low the sequencer position does not move. With cpu_ce high on alternate clocks, the waveform period in clocks doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_ofs | input | 2 | Register offset |
| wr_data | input | 8 | Register write data |
| env_vol | input | 4 | Current envelope volume |
| len_active | input | 1 | Length counter is nonzero |
| sweep_mute | input | 1 | Sweep unit silences the channel |
| level | output | 4 | Gated sample to the mixer |
| env_restart | output | 1 | One-cycle envelope restart pulse |

## Verification
The bench builds the block with its default parameters: an 11-bit period, a 4-bit level, a mute threshold of 8 and the divide-by-two stage enabled. These values make the threshold at 7 and 8 reachable with low-byte writes alone. They also allow periods with high-byte bits set to be measured within a few thousand clocks, and let the halved enable rate be seen as a doubled waveform period. Freezing cpu_ce fixes the sequencer at a known position, which isolates the effects of duty changes, offset-1 writes and mute inputs.

// File: rtl/sqch_pkg.sv
package sqch_pkg;

   localparam int STEPS  = 8;
   localparam int STEP_W = $clog2(STEPS);
   localparam int DUTY_W = 2;

   typedef logic [STEP_W-1:0] step_t;
   typedef logic [DUTY_W-1:0] duty_t;

   typedef enum logic [1:0] {
      OFS_CTRL   = 2'd0,
      OFS_SPARE  = 2'd1,
      OFS_PER_LO = 2'd2,
      OFS_PER_HI = 2'd3
   } ofs_e;

   // Pattern bit at a sequencer position; the position counts downward.
   function automatic logic pattern_bit(input duty_t d, input step_t s);
      logic [STEPS-1:0] mask;
      case (d)
         2'd0:    mask = 8'b0000_0010;
         2'd1:    mask = 8'b0000_0110;
         2'd2:    mask = 8'b0001_1110;
         default: mask = 8'b1111_1001;
      endcase
      return mask[s];
   endfunction

endpackage

// File: rtl/sqch_regs.sv
module sqch_regs
   import sqch_pkg::*;
#(
   parameter int PERIOD_W = 11,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_ofs,
   input  logic [DATA_W-1:0]   wr_data,
   output duty_t               duty,
   output logic [PERIOD_W-1:0] period,
   output logic                restart,
   output logic                restart_q
);

   localparam int LO_W = DATA_W;
   localparam int HI_W = PERIOD_W - LO_W;

   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;
   duty_t           duty_q;
   logic            hit_ctrl, hit_lo, hit_hi;

   assign hit_ctrl = wr_en && (ofs_e'(wr_ofs) == OFS_CTRL);
   assign hit_lo   = wr_en && (ofs_e'(wr_ofs) == OFS_PER_LO);
   assign hit_hi   = wr_en && (ofs_e'(wr_ofs) == OFS_PER_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q    <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         restart_q <= 1'b0;
      end else begin
         restart_q <= hit_hi;
         if (hit_ctrl) duty_q <= wr_data[DATA_W-1 -: DUTY_W];
         if (hit_lo)   lo_q   <= wr_data;
         if (hit_hi)   hi_q   <= wr_data[HI_W-1:0];
      end
   end

   logic data_unused;
   assign data_unused = ^wr_data[DATA_W-DUTY_W-1:HI_W];

   assign duty    = duty_q;
   assign period  = {hi_q, lo_q};
   assign restart = hit_hi;

endmodule

// File: rtl/sqch_timer.sv
module sqch_timer #(
   parameter int PERIOD_W = 11,
   parameter bit HALVE_CE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_ce,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);

   logic apu_ce;

   generate
      if (HALVE_CE) begin : g_halve
         logic phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      phase_q <= 1'b0;
            else if (cpu_ce) phase_q <= ~phase_q;
         end
         assign apu_ce = cpu_ce && phase_q;
      end else begin : g_direct
         assign apu_ce = cpu_ce;
      end
   endgenerate

   logic [PERIOD_W-1:0] cnt_q;
   logic                expire;

   assign expire = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (apu_ce) cnt_q <= expire ? period : cnt_q - 1'b1;
   end

   assign tick = apu_ce && expire;

endmodule

// File: rtl/sqch_seq.sv
module sqch_seq
   import sqch_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  restart,
   input  duty_t duty,
   output step_t step,
   output logic  wave
);

   step_t step_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       step_q <= '0;
      else if (restart) step_q <= '0;
      else if (tick)    step_q <= step_q - 1'b1;
   end

   assign step = step_q;
   assign wave = pattern_bit(duty, step_q);

endmodule

// File: rtl/sqch_gate.sv
module sqch_gate #(
   parameter int PERIOD_W = 11,
   parameter int LEVEL_W  = 4,
   parameter int MUTE_MIN = 8
) (
   input  logic [PERIOD_W-1:0] period,
   input  logic                wave,
   input  logic [LEVEL_W-1:0]  env_vol,
   input  logic                len_active,
   input  logic                sweep_mute,
   output logic [LEVEL_W-1:0]  level
);

   logic too_fast, pass;

   assign too_fast = (period < PERIOD_W'(MUTE_MIN));
   assign pass     = wave && len_active && !sweep_mute && !too_fast;
   assign level    = pass ? env_vol : '0;

endmodule

// File: rtl/sqch_core.sv
module sqch_core
   import sqch_pkg::*;
#(
   parameter int PERIOD_W = 11,
   parameter int LEVEL_W  = 4,
   parameter int DATA_W   = 8,
   parameter int MUTE_MIN = 8,
   parameter bit HALVE_CE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_ce,
   input  logic               wr_en,
   input  logic [1:0]         wr_ofs,
   input  logic [7:0]         wr_data,
   input  logic [LEVEL_W-1:0] env_vol,
   input  logic               len_active,
   input  logic               sweep_mute,
   output logic [LEVEL_W-1:0] level,
   output logic               env_restart
);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("sqch_core: DATA_W must be 8");
      end
      if (PERIOD_W <= DATA_W || PERIOD_W > 2*DATA_W) begin : g_bad_period
         $error("sqch_core: PERIOD_W must lie in (DATA_W, 2*DATA_W]");
      end
      if (MUTE_MIN < 0 || MUTE_MIN >= (1 << PERIOD_W)) begin : g_bad_mute
         $error("sqch_core: MUTE_MIN out of range");
      end
      if (LEVEL_W < 1) begin : g_bad_level
         $error("sqch_core: LEVEL_W must be positive");
      end
   endgenerate

   duty_t               duty_w;
   logic [PERIOD_W-1:0] period_w;
   logic                restart_w;
   logic                tick_w;
   step_t               step_w;
   logic                wave_w;

   sqch_regs #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_ofs    (wr_ofs),
      .wr_data   (wr_data),
      .duty      (duty_w),
      .period    (period_w),
      .restart   (restart_w),
      .restart_q (env_restart)
   );

   sqch_timer #(.PERIOD_W(PERIOD_W), .HALVE_CE(HALVE_CE)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .cpu_ce (cpu_ce),
      .period (period_w),
      .tick   (tick_w)
   );

   sqch_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_w),
      .restart (restart_w),
      .duty    (duty_w),
      .step    (step_w),
      .wave    (wave_w)
   );

   sqch_gate #(.PERIOD_W(PERIOD_W), .LEVEL_W(LEVEL_W), .MUTE_MIN(MUTE_MIN)) u_gate (
      .period     (period_w),
      .wave       (wave_w),
      .env_vol    (env_vol),
      .len_active (len_active),
      .sweep_mute (sweep_mute),
      .level      (level)
   );

endmodule

// File: rtl/sqch_core_chk.sv
module sqch_core_chk
   import sqch_pkg::*;
#(
   parameter int PERIOD_W = 11,
   parameter int LEVEL_W  = 4,
   parameter int MUTE_MIN = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_ce,
   input logic                wr_en,
   input logic [1:0]          wr_ofs,
   input logic                len_active,
   input logic                sweep_mute,
   input logic [LEVEL_W-1:0]  level,
   input logic                env_restart,
   input step_t               step,
   input duty_t               duty,
   input logic [PERIOD_W-1:0] period
);

   logic wr_hi, wr_spare, wr_ctrl;
   assign wr_hi    = wr_en && (wr_ofs == 2'd3);
   assign wr_spare = wr_en && (wr_ofs == 2'd1);
   assign wr_ctrl  = wr_en && (wr_ofs == 2'd0);

   p_short_period_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (period < PERIOD_W'(MUTE_MIN)) |-> (level == '0));

   p_len_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!len_active || sweep_mute) |-> (level == '0));

   p_restart_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (env_restart && step == '0));

   p_restart_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      env_restart |-> $past(wr_hi));

   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> (step == $past(step) || step == step_t'($past(step) - 1'b1)));

   p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ce && !wr_hi) |=> $stable(step));

   p_duty_keeps_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !cpu_ce) |=> $stable(step));

   p_spare_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_spare |=> ($stable(duty) && $stable(period) && !env_restart));

endmodule

bind sqch_core sqch_core_chk #(
   .PERIOD_W (PERIOD_W),
   .LEVEL_W  (LEVEL_W),
   .MUTE_MIN (MUTE_MIN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_ce      (cpu_ce),
   .wr_en       (wr_en),
   .wr_ofs      (wr_ofs),
   .len_active  (len_active),
   .sweep_mute  (sweep_mute),
   .level       (level),
   .env_restart (env_restart),
   .step        (step_w),
   .duty        (duty_w),
   .period      (period_w)
);

// File: tb/sqch_core_test.sv
module sqch_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_ce = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_ofs = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [3:0] env_vol = 4'd9;
   logic       len_active = 1'b1;
   logic       sweep_mute = 1'b0;
   logic [3:0] level;
   logic       env_restart;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #2.5 clk = ~clk;

   sqch_core uut (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_ofs(wr_ofs), .wr_data(wr_data), .env_vol(env_vol),
      .len_active(len_active), .sweep_mute(sweep_mute),
      .level(level), .env_restart(env_restart)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step_clk();
      @(posedge clk);
      #1;
   endtask

   task automatic reg_write(input logic [1:0] ofs, input logic [7:0] d);
      wr_en = 1'b1; wr_ofs = ofs; wr_data = d;
      step_clk();
      wr_en = 1'b0;
   endtask

   task automatic set_period(input int t);
      reg_write(2'd2, 8'(t));
      reg_write(2'd3, 8'(t >> 8));
   endtask

   // Clocks between two rising edges of level; half selects alternate-clock enables.
   task automatic measure_period(input bit half, output int span);
      logic [3:0] prev;
      int first, now;
      bit seen;
      seen = 0; first = 0; span = 0; now = 0;
      prev = level;
      for (int i = 0; i < 20000; i++) begin
         cpu_ce = half ? ~cpu_ce : 1'b1;
         step_clk();
         now++;
         if (prev == 0 && level != 0) begin
            if (seen) begin span = now - first; break; end
            seen = 1; first = now;
         end
         prev = level;
      end
      cpu_ce = 1'b0;
   endtask

   task automatic test_reset();
      check("R1 level after reset", level, 0);
      check("R1 restart after reset", env_restart, 0);
   endtask

   task automatic test_periods();
      int span;
      reg_write(2'd0, 8'h80);
      set_period(10);
      measure_period(1'b0, span);
      check("R2 period t=10", span, 16*11);
      set_period(268);
      measure_period(1'b0, span);
      check("R2 period t=268 high bits", span, 16*269);
      set_period(8);
      measure_period(1'b0, span);
      check("R7 period t=8 audible", span, 16*9);
      set_period(10);
      measure_period(1'b1, span);
      check("R10 halved enable doubles period", span, 32*11);
   endtask

   task automatic test_duty();
      int highs;
      int ones [4] = '{1, 2, 4, 6};
      set_period(10);
      for (int d = 0; d < 4; d++) begin
         reg_write(2'd0, 8'(d << 6));
         cpu_ce = 1'b1;
         for (int i = 0; i < 32; i++) step_clk();
         highs = 0;
         for (int i = 0; i < 16*11; i++) begin
            step_clk();
            if (level != 0) highs++;
         end
         cpu_ce = 1'b0;
         check($sformatf("R3 high clocks duty %0d", d), highs, ones[d]*2*11);
      end
   endtask

   task automatic test_restart_and_order();
      int guard;
      reg_write(2'd0, 8'hC0);
      wr_en = 1'b1; wr_ofs = 2'd3; wr_data = 8'h00;
      step_clk();
      wr_en = 1'b0;
      check("R6 restart pulse", env_restart, 1);
      check("R6 duty3 at position 0", level, 9);
      step_clk();
      check("R6 restart pulse one clock", env_restart, 0);
      check("R10 frozen without enable", level, 9);
      reg_write(2'd0, 8'h80);
      check("R4 duty2 at position 0 low", level, 0);
      reg_write(2'd0, 8'hC0);
      cpu_ce = 1'b1;
      guard = 0;
      while (level != 0 && guard < 2000) begin step_clk(); guard++; end
      cpu_ce = 1'b0;
      check("R4 duty3 high for positions 0,7..3", guard > 2*11*5 ? 1 : 0, 1);
      reg_write(2'd0, 8'h80);
      check("R5 duty2 at kept position 2", level, 9);
      reg_write(2'd0, 8'h00);
      check("R5 duty0 at kept position 2", level, 0);
      reg_write(2'd0, 8'h40);
      check("R5 duty1 at kept position 2", level, 9);
   endtask

   task automatic test_gating();
      reg_write(2'd1, 8'hFF);
      check("R9 spare write keeps level", level, 9);
      check("R9 spare write no restart", env_restart, 0);
      reg_write(2'd2, 8'd7);
      check("R7 period 7 muted", level, 0);
      reg_write(2'd2, 8'd8);
      check("R7 period 8 audible", level, 9);
      len_active = 1'b0; step_clk();
      check("R8 length zero mutes", level, 0);
      len_active = 1'b1; sweep_mute = 1'b1; step_clk();
      check("R8 sweep mutes", level, 0);
      sweep_mute = 1'b0; env_vol = 4'd5; step_clk();
      check("R8 passes envelope volume", level, 5);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) step_clk();
      rst_n = 1'b1;
      step_clk();
      test_reset();
      test_periods();
      test_duty();
      test_restart_and_order();
      test_gating();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
         end
      end
   end

endmodule